// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks which way of a set-associative cache (one to four ways) is to be overwritten when a line is refilled. It keeps a small history word for every cache line, addressed by line index. On every lookup that hits, the cache reports the line and the way that hit. On a refill, the cache presents the line index and reads back the way to evict in the same cycle. That history word is then updated at the next clock edge.

A parameter sets the replacement policy:
- **Random** uses a free-running counter.
- **Least-recently-replaced** (two ways only) keeps one bit per line.
- **Least-recently-used** keeps 1, 3 or 5 bits per line for 2, 3 or 4 ways.

An optional lock bit per way and line keeps pinned data resident. When every way of a line is locked, the block reports that the refill cannot be cached.

Top module: `way_victim_sel`

## Requirements
- R1: With one way the victim is always way 0. The uncacheable flag rises only when that way's lock bit is set for the presented line.
- R2: Random policy: a counter of 1 bit (2 ways) or 2 bits (3 or 4 ways) starts at 0 after reset and advances on every clock. The victim is the counter value, with 3 folded to way 0 in a 3-way cache. If that way is locked, the next unlocked way counting upward with wrap is chosen.
- R3: Least-recently-replaced policy (2 ways): each line stores the way last refilled, and the victim is the other way. Only a committed refill changes this bit. Hit reports have no effect.
- R4: Least-recently-used policy: the victim is the way of the line least recently hit or refilled. Both a hit and a committed refill make the way involved the most recent one. After reset the recency order of a line, from most to least recent, is way 0, 1, 2, 3, so way WAYS-1 is the first victim.
- R5: When a hit report and a committed refill name the same line in one cycle, the refill's update wins and the hit is dropped.
- R6: A way whose lock bit is set is never returned as victim. The policy's next candidate is used instead: for least-recently-used, the next-oldest way; otherwise, the next way upward with wrap. A lock write (line, way, value) takes effect at the next clock edge.
- R7: If all ways of the presented line are locked, the uncacheable flag is 1. A refill request in that state leaves the history unchanged.
- R8: Reset clears all history, all lock bits and the random counter. A flush pulse clears all history on the next edge but leaves the lock bits as they are.
- R9: The victim and the uncacheable flag follow the presented refill line combinationally, in the same cycle. History changes become visible one cycle after the edge that commits them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all replacement history |
| acc_valid | input | 1 | A hit is being reported this cycle |
| acc_line | input | LW | Line index of the hit |
| acc_way | input | WW | Way that hit |
| fill_req | input | 1 | Commit a refill of `fill_line` into `vic_way` |
| fill_line | input | LW | Line index being refilled (also the victim query) |
| lock_we | input | 1 | Write one lock bit |
| lock_line | input | LW | Line index of the lock write |
| lock_way | input | WW | Way of the lock write |
| lock_val | input | 1 | New lock bit value |
| vic_way | output | WW | Way to evict for `fill_line` |
| vic_none | output | 1 | All ways of `fill_line` are locked; refill is uncacheable |

## Verification
Some properties are checked on every cycle:
- a returned victim is never locked, and lies within the way count;
- the uncacheable flag appears only on a fully locked line;
- history reads as zero after a flush;
- under least-recently-used, the way just hit or refilled becomes the most recent;
- under least-recently-replaced, the stored bit tracks refills and ignores other cycles;
- the random counter steps once per clock.

Other behaviours need the bench's scenarios:
- whole recency sequences over several hits;
- the same-line hit and refill collision;
- substitution order when some ways are locked;
- the fold of counter value 3;
- lock bits surviving a flush.

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel #(
  parameter int WAYS    = 4,
  parameter int LINES   = 64,
  parameter int POLICY  = 2,
  parameter bit LOCK_EN = 1'b1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          acc_valid,
  input  logic [LW-1:0] acc_line,
  input  logic [WW-1:0] acc_way,
  input  logic          fill_req,
  input  logic [LW-1:0] fill_line,
  input  logic          lock_we,
  input  logic [LW-1:0] lock_line,
  input  logic [WW-1:0] lock_way,
  input  logic          lock_val,
  output logic [WW-1:0] vic_way,
  output logic          vic_none
);

  localparam int P_RAND = 0;
  localparam int P_LRR  = 1;
  localparam int P_LRU  = 2;
  localparam int CW = (WAYS > 2) ? 2 : 1;
  localparam int SW = (POLICY == P_LRU && WAYS == 4) ? 5 :
                      (POLICY == P_LRU && WAYS == 3) ? 3 : 1;

  logic [SW-1:0]   hist   [LINES];
  logic [WAYS-1:0] lock_q [LINES];
  logic [CW-1:0]   rcnt;
  logic            up;

  logic [4:0] hf, ha, fill_nx, acc_nx;
  logic [3:0] lf;
  logic [7:0] ordf;
  logic [1:0] cand, vsel;
  logic       none_c;
  int         w;

  // k-th way (ascending) not present in the used mask
  function automatic logic [1:0] nth_free(input logic [3:0] used, input int k);
    logic [1:0] r;
    int seen;
    r = 2'd0;
    seen = 0;
    for (int i = 0; i < WAYS; i++) begin
      if (!used[i]) begin
        if (seen == k) r = 2'(i);
        seen++;
      end
    end
    return r;
  endfunction

  // history word -> recency order, slot 0 most recent
  function automatic logic [7:0] decode(input logic [4:0] c);
    logic [1:0] o0, o1, o2, o3;
    logic [3:0] m;
    o0 = 2'd0; o1 = 2'd0; o2 = 2'd0; o3 = 2'd0;
    if (WAYS == 2) begin
      o0 = {1'b0, c[0]};
      o1 = {1'b0, ~c[0]};
    end else if (WAYS == 3) begin
      o0 = (c[1:0] == 2'd3) ? 2'd2 : c[1:0];
      m  = 4'd1 << o0;
      o1 = nth_free(m, int'(c[2]));
      m  = m | (4'd1 << o1);
      o2 = nth_free(m, 0);
    end else if (WAYS == 4) begin
      o0 = c[1:0];
      m  = 4'd1 << o0;
      o1 = nth_free(m, (c[3:2] == 2'd3) ? 2 : int'(c[3:2]));
      m  = m | (4'd1 << o1);
      o2 = nth_free(m, int'(c[4]));
      m  = m | (4'd1 << o2);
      o3 = nth_free(m, 0);
    end
    return {o3, o2, o1, o0};
  endfunction

  // move way u to the front of the order and re-encode
  function automatic logic [4:0] touch(input logic [4:0] c, input logic [1:0] u);
    logic [7:0] od;
    logic [1:0] n [4];
    logic [1:0] r;
    logic [4:0] e;
    int j;
    od = decode(c);
    n[0] = u; n[1] = 2'd0; n[2] = 2'd0; n[3] = 2'd0;
    j = 1;
    for (int i = 0; i < WAYS; i++) begin
      if (od[2*i +: 2] != u && j < 4) begin
        n[j] = od[2*i +: 2];
        j++;
      end
    end
    e = '0;
    if (WAYS == 2) begin
      e[0] = n[0][0];
    end else if (WAYS == 3) begin
      e[1:0] = n[0];
      r = n[1] - ((n[0] < n[1]) ? 2'd1 : 2'd0);
      e[2] = r[0];
    end else if (WAYS == 4) begin
      e[1:0] = n[0];
      r = n[1] - ((n[0] < n[1]) ? 2'd1 : 2'd0);
      e[3:2] = r;
      r = n[2] - ((n[0] < n[2]) ? 2'd1 : 2'd0) - ((n[1] < n[2]) ? 2'd1 : 2'd0);
      e[4] = r[0];
    end
    return e;
  endfunction

  always_comb begin
    hf = '0;
    hf[SW-1:0] = hist[fill_line];
    ha = '0;
    ha[SW-1:0] = hist[acc_line];
    lf = '0;
    if (LOCK_EN) lf[WAYS-1:0] = lock_q[fill_line];
    ordf = decode(hf);
    cand = '0;
    if (POLICY == P_RAND) begin
      cand = 2'(rcnt);
      if (int'(cand) >= WAYS) cand = 2'(int'(cand) - WAYS);
    end else if (POLICY == P_LRR) begin
      cand = {1'b0, ~hf[0]};
    end
    vsel = '0;
    none_c = 1'b1;
    w = 0;
    if (POLICY == P_LRU) begin
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (none_c && !lf[ordf[2*i +: 2]]) begin
          vsel = ordf[2*i +: 2];
          none_c = 1'b0;
        end
      end
    end else begin
      for (int k = 0; k < WAYS; k++) begin
        w = int'(cand) + k;
        if (w >= WAYS) w = w - WAYS;
        if (none_c && !lf[w]) begin
          vsel = 2'(w);
          none_c = 1'b0;
        end
      end
    end
    fill_nx = (POLICY == P_LRU) ? touch(hf, vsel) : {4'b0, vsel[0]};
    acc_nx  = touch(ha, 2'(acc_way));
  end

  assign vic_way  = vsel[WW-1:0];
  assign vic_none = none_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      up   <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        hist[i]   <= '0;
        lock_q[i] <= '0;
      end
    end else begin
      rcnt <= rcnt + CW'(1);
      up   <= 1'b1;
      if (flush) begin
        for (int i = 0; i < LINES; i++) hist[i] <= '0;
      end else begin
        if (POLICY == P_LRU && acc_valid && !(fill_req && fill_line == acc_line))
          hist[acc_line] <= acc_nx[SW-1:0];
        if (POLICY != P_RAND && fill_req && !none_c)
          hist[fill_line] <= fill_nx[SW-1:0];
      end
      if (LOCK_EN && lock_we && int'(lock_way) < WAYS)
        lock_q[lock_line][lock_way] <= lock_val;
    end
  end

  a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_none |-> !lock_q[fill_line][vic_way]);

  a_r7_none_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    vic_none |-> (&lock_q[fill_line]));

  a_r9_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vic_way) < WAYS);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $past(flush)) |-> hf == '0);

  generate
    if (POLICY == P_LRU && WAYS > 1) begin : g_lru_chk
      a_r4_hit_most_recent: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(acc_valid && !flush && !(fill_req && fill_line == acc_line))
           && fill_line == $past(acc_line))
        |-> ordf[1:0] == $past(2'(acc_way)));
      a_r5_fill_most_recent: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(fill_req && !vic_none && !flush) && fill_line == $past(fill_line))
        |-> ordf[1:0] == $past(vsel));
    end
    if (POLICY == P_LRR) begin : g_lrr_chk
      a_r3_records_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(fill_req && !vic_none && !flush) && fill_line == $past(fill_line))
        |-> hf[0] == $past(vic_way[0]));
      a_r3_hits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(!fill_req && !flush) && fill_line == $past(fill_line))
        |-> hf == $past(hf));
    end
    if (POLICY == P_RAND) begin : g_rnd_chk
      a_r2_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> rcnt == $past(rcnt) + CW'(1));
    end
    if (WAYS == 1) begin : g_dm_chk
      a_r1_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        vic_way == '0);
    end
  endgenerate

endmodule

// File: tb/way_victim_sel_test.sv
`timescale 1ns/1ps
module way_victim_sel_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, flush = 1'b0;
  logic       acc_valid = 1'b0, fill_req = 1'b0, lock_we = 1'b0, lock_val = 1'b0;
  logic [3:0] acc_line = '0, fill_line = '0, lock_line = '0;
  logic [1:0] acc_way = '0, lock_way = '0;
  logic [1:0] v4, v3;
  logic       v2, v1, n4, n3, n2, n1;
  int nv = 0, nf = 0, cyc = 0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  way_victim_sel #(.WAYS(4), .LINES(16), .POLICY(2)) uut (
    .clk, .rst_n, .flush, .acc_valid, .acc_line, .acc_way, .fill_req, .fill_line,
    .lock_we, .lock_line, .lock_way, .lock_val, .vic_way(v4), .vic_none(n4));
  way_victim_sel #(.WAYS(3), .LINES(16), .POLICY(0)) u_rnd (
    .clk, .rst_n, .flush, .acc_valid, .acc_line, .acc_way, .fill_req, .fill_line,
    .lock_we, .lock_line, .lock_way, .lock_val, .vic_way(v3), .vic_none(n3));
  way_victim_sel #(.WAYS(2), .LINES(16), .POLICY(1)) u_lrr (
    .clk, .rst_n, .flush, .acc_valid, .acc_line, .acc_way(acc_way[0:0]), .fill_req, .fill_line,
    .lock_we, .lock_line, .lock_way(lock_way[0:0]), .lock_val, .vic_way(v2), .vic_none(n2));
  way_victim_sel #(.WAYS(1), .LINES(16), .POLICY(2)) u_dm (
    .clk, .rst_n, .flush, .acc_valid, .acc_line, .acc_way(acc_way[0:0]), .fill_req, .fill_line,
    .lock_we, .lock_line, .lock_way(lock_way[0:0]), .lock_val, .vic_way(v1), .vic_none(n1));

  task automatic chk(input string req, input int got, input int exp);
    nv++;
    if (got != exp) begin
      nf++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic peek(input int l);
    @(negedge clk);
    fill_line = 4'(l);
    #1;
  endtask

  task automatic access(input int l, input int wy);
    @(negedge clk);
    acc_valid = 1'b1; acc_line = 4'(l); acc_way = 2'(wy);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic fill(input int l);
    @(negedge clk);
    fill_line = 4'(l); fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic lockw(input int l, input int wy, input bit v);
    @(negedge clk);
    lock_we = 1'b1; lock_line = 4'(l); lock_way = 2'(wy); lock_val = v;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic t_reset;
    peek(0);
    chk("R8 reset lru victim", int'(v4), 3);
    chk("R8 reset lru none", int'(n4), 0);
    chk("R3 reset lrr victim", int'(v2), 1);
    chk("R1 single way victim", int'(v1), 0);
    chk("R1 single way none", int'(n1), 0);
  endtask

  task automatic t_lru;
    access(2, 3); peek(2); chk("R4 after hit 3", int'(v4), 2);
    access(2, 2); peek(2); chk("R4 after hit 2", int'(v4), 1);
    access(2, 1); peek(2); chk("R4 after hit 1", int'(v4), 0);
    access(2, 0); peek(2); chk("R4 after hit 0", int'(v4), 3);
    fill(2); peek(2); chk("R4 refill most recent", int'(v4), 2);
    fill_line = 4'd0; #1;
    chk("R9 same-cycle victim", int'(v4), 3);
  endtask

  task automatic t_collide;
    @(negedge clk);
    acc_valid = 1'b1; acc_line = 4'd5; acc_way = 2'd0;
    fill_req = 1'b1; fill_line = 4'd5;
    #1 chk("R5 victim before commit", int'(v4), 3);
    @(negedge clk);
    acc_valid = 1'b0; fill_req = 1'b0;
    peek(5); chk("R5 refill wins", int'(v4), 2);
  endtask

  task automatic t_lock;
    lockw(7, 3, 1'b1); peek(7); chk("R6 skip locked oldest", int'(v4), 2);
    lockw(7, 2, 1'b1); lockw(7, 1, 1'b1); peek(7);
    chk("R6 only way 0 free", int'(v4), 0);
    lockw(7, 0, 1'b1); peek(7); chk("R7 all locked", int'(n4), 1);
    fill(7);
    lockw(7, 3, 1'b0); peek(7);
    chk("R7 history unchanged", int'(v4), 3);
    chk("R7 cacheable again", int'(n4), 0);
  endtask

  task automatic t_lrr;
    peek(3); chk("R3 initial", int'(v2), 1);
    access(3, 1); peek(3); chk("R3 hit ignored", int'(v2), 1);
    fill(3); peek(3); chk("R3 after refill 1", int'(v2), 0);
    fill(3); peek(3); chk("R3 after refill 0", int'(v2), 1);
    lockw(3, 1, 1'b1); peek(3); chk("R6 lrr substitute", int'(v2), 0);
    lockw(3, 1, 1'b0);
  endtask

  task automatic t_random;
    int e;
    peek(9);
    for (int s = 0; s < 6; s++) begin
      @(negedge clk); #1;
      e = cyc % 4; if (e == 3) e = 0;
      chk("R2 counter victim", int'(v3), e);
    end
    lockw(9, 1, 1'b1);
    for (int s = 0; s < 6; s++) begin
      @(negedge clk); #1;
      e = cyc % 4; if (e == 3) e = 0; if (e == 1) e = 2;
      chk("R2 R6 random skip lock", int'(v3), e);
    end
    chk("R2 not full", int'(n3), 0);
    lockw(9, 1, 1'b0);
  endtask

  task automatic t_flush;
    fill(3); peek(3); chk("R3 before flush", int'(v2), 0);
    lockw(7, 3, 1'b1);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    peek(2); chk("R8 lru cleared", int'(v4), 3);
    peek(3); chk("R8 lrr cleared", int'(v2), 1);
    peek(7); chk("R8 locks kept", int'(n4), 1);
  endtask

  task automatic t_dm;
    peek(4); chk("R1 victim", int'(v1), 0); chk("R1 free", int'(n1), 0);
    lockw(4, 0, 1'b1); peek(4); chk("R1 locked", int'(n1), 1);
    lockw(4, 0, 1'b0); peek(4); chk("R1 unlocked", int'(n1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_lru;
    t_collide;
    t_lock;
    t_lrr;
    t_random;
    t_flush;
    t_dm;
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end

  initial begin
    #1000000;
    nf++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end
endmodule